// File: doc/BRIEF.md
# Trimmed-Rate Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. It runs from a reference clock that is faster than the nominal time clock. On every enabled reference cycle, a 32-bit accumulator adds a programmable addend. When that addition carries out, the time value steps forward by the nominal period in nanoseconds. The average step rate is therefore reference_freq × addend / 2^32. Software trims the clock by rewriting the addend: a larger addend gives more frequent carries, so the clock runs faster. The nominal addend is ceil(2^32 × nominal_freq / reference_freq). The nominal frequency must be below the reference frequency and must divide 1000 MHz evenly, which makes the period field 1e9 / nominal_freq.

A separate 64-bit offset is added to the raw count to form the reported time. Software can therefore shift time without touching the running count. All values are reached through a 32-bit register bus. The 64-bit quantities are handled as two words, and the low word always goes first. Reading the low word of the count freezes the matching high word, so the two reads form one coherent value. Writing a low word only stages it, and the write of the high word commits all 64 bits at once.

Top module: `tmc_top`

## Requirements
- R1: After synchronous reset the raw count, offset, accumulator and enable are zero, the tick is low, the period field holds PER_RST (10) and the addend holds ADDEND_RST (0xCCCCCCCD).
- R2: On each clock edge with enable set, the addend is added to the 32-bit accumulator. When that sum carries out, the raw count grows by the period field in the same edge. The count after N enabled cycles from a zero accumulator is start + floor(N × addend / 2^32) × period.
- R3: `tick_o` is high for exactly the one cycle that follows each counting step. The number of tick cycles equals the number of carries.
- R4: With enable clear, the raw count and the accumulator hold and no tick occurs. After enable is set again, counting resumes from the held accumulator phase.
- R5: `time_o` always equals raw count plus offset, modulo 2^64. Writing the offset never changes the raw count.
- R6: A read of address 2 returns the live low 32 bits of the count and captures the high 32 bits into a shadow. A read of address 3 returns that shadow, even if the count has since carried into its high word.
- R7: A write to address 2 only stages the low word, and the count does not change. A write to address 3 loads {written word, staged word} into the count at that edge, and this takes priority over a counting step in the same edge.
- R8: The offset low word (address 4) is staged, and a write to address 5 commits {written word, staged word}. Both words read back, and the offset changes at no other time.
- R9: Address 0 is the control register: bit 0 is the enable and bits 15:8 are the period field. All other bits read as zero. Address 1 holds the addend for read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the high-word snapshot) |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register, combinational |
| raw_cnt_o | output | 64 | Raw nanosecond count |
| time_o | output | 64 | Raw count plus offset |
| tick_o | output | 1 | One-cycle pulse after each counting step |

## Verification
The rate logic is exercised with directed addends and with seeded random ones. The directed addends are zero (no motion), exactly one half (a step on every second cycle) and all-ones (a step on every cycle after the first). Each random run uses its own period, start value and run length. Comparing the step count against floor(N × addend / 2^32) exposes an off-by-one in the carry, a wrong increment width, or a lost first or last cycle. A pause in the middle of each random run checks that both the count and the accumulator phase hold. The word-order cases let the count cross its 32-bit boundary between the two reads, and they commit a load during an active carry, which separates a coherent shadow from a live read and a load that wins from one that loses to the step.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    localparam int BUS_W  = 32;
    localparam int CNT_W  = 2 * BUS_W;
    localparam int ADDR_W = 3;

    // Control word field positions
    localparam int EN_BIT  = 0;
    localparam int PER_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_ADDEND = 3'd1,
        SEL_CNT_LO = 3'd2,
        SEL_CNT_HI = 3'd3,
        SEL_OFF_LO = 3'd4,
        SEL_OFF_HI = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] value;
    } cnt_load_t;

    function automatic logic [CNT_W-1:0] join_words(input logic [BUS_W-1:0] hi,
                                                    input logic [BUS_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/tmc_accum.sv
module tmc_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] addend,
    output logic             carry_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, addend};
        carry_o = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= sum[ACC_W-1:0];
    end
endmodule

// File: rtl/tmc_count.sv
module tmc_count
    import tmc_pkg::*;
#(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step,
    input  logic [PER_W-1:0] period,
    input  cnt_load_t        load,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o
);
    localparam int PAD = CNT_W - PER_W;

    logic [CNT_W-1:0] incr;
    assign incr = {{PAD{1'b0}}, period};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= en & step;
            if (load.load)
                cnt_o <= load.value;
            else if (en && step)
                cnt_o <= cnt_o + incr;
        end
    end
endmodule

// File: rtl/tmc_regfile.sv
module tmc_regfile
    import tmc_pkg::*;
#(
    parameter int               PER_W      = 8,
    parameter logic [PER_W-1:0] PER_RST    = 10,
    parameter logic [BUS_W-1:0] ADDEND_RST = 32'hCCCC_CCCD
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [BUS_W-1:0] rdata,
    output logic             en_o,
    output logic [PER_W-1:0] period_o,
    output logic [BUS_W-1:0] addend_o,
    output logic [CNT_W-1:0] offset_o,
    output cnt_load_t        cnt_load_o
);
    logic [BUS_W-1:0] cnt_stage;
    logic [BUS_W-1:0] off_stage;
    logic [BUS_W-1:0] cnt_shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o       <= 1'b0;
            period_o   <= PER_RST;
            addend_o   <= ADDEND_RST;
            offset_o   <= '0;
            cnt_stage  <= '0;
            off_stage  <= '0;
            cnt_shadow <= '0;
        end else begin
            if (req.wr) begin
                case (req.sel)
                    SEL_CTRL: begin
                        en_o     <= req.data[EN_BIT];
                        period_o <= req.data[PER_LSB +: PER_W];
                    end
                    SEL_ADDEND: addend_o  <= req.data;
                    SEL_CNT_LO: cnt_stage <= req.data;
                    SEL_OFF_LO: off_stage <= req.data;
                    SEL_OFF_HI: offset_o  <= join_words(req.data, off_stage);
                    default: ;
                endcase
            end
            if (req.rd && req.sel == SEL_CNT_LO)
                cnt_shadow <= cnt_i[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        cnt_load_o.load  = req.wr && (req.sel == SEL_CNT_HI);
        cnt_load_o.value = join_words(req.data, cnt_stage);
    end

    always_comb begin
        rdata = '0;
        case (req.sel)
            SEL_CTRL: begin
                rdata[EN_BIT]           = en_o;
                rdata[PER_LSB +: PER_W] = period_o;
            end
            SEL_ADDEND: rdata = addend_o;
            SEL_CNT_LO: rdata = cnt_i[BUS_W-1:0];
            SEL_CNT_HI: rdata = cnt_shadow;
            SEL_OFF_LO: rdata = offset_o[BUS_W-1:0];
            SEL_OFF_HI: rdata = offset_o[CNT_W-1:BUS_W];
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmc_top.sv
module tmc_top
    import tmc_pkg::*;
#(
    parameter int               PER_W      = 8,
    parameter logic [PER_W-1:0] PER_RST    = 10,
    parameter logic [BUS_W-1:0] ADDEND_RST = 32'hCCCC_CCCD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  raw_cnt_o,
    output logic [CNT_W-1:0]  time_o,
    output logic              tick_o
);
    bus_req_t         req;
    cnt_load_t        cnt_load_w;
    logic             en_w;
    logic             carry_w;
    logic [PER_W-1:0] period_w;
    logic [BUS_W-1:0] addend_w;
    logic [CNT_W-1:0] offset_w;
    logic             load_en_w;
    logic [CNT_W-1:0] load_val_w;

    always_comb begin
        req.wr   = bus_wr;
        req.rd   = bus_rd;
        req.sel  = reg_sel_e'(bus_addr);
        req.data = bus_wdata;
    end

    tmc_regfile #(
        .PER_W     (PER_W),
        .PER_RST   (PER_RST),
        .ADDEND_RST(ADDEND_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .cnt_i     (raw_cnt_o),
        .rdata     (bus_rdata),
        .en_o      (en_w),
        .period_o  (period_w),
        .addend_o  (addend_w),
        .offset_o  (offset_w),
        .cnt_load_o(cnt_load_w)
    );

    tmc_accum #(.ACC_W(BUS_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .en     (en_w),
        .addend (addend_w),
        .carry_o(carry_w)
    );

    tmc_count #(.PER_W(PER_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .en    (en_w),
        .step  (carry_w),
        .period(period_w),
        .load  (cnt_load_w),
        .cnt_o (raw_cnt_o),
        .tick_o(tick_o)
    );

    assign load_en_w  = cnt_load_w.load;
    assign load_val_w = cnt_load_w.value;
    assign time_o     = raw_cnt_o + offset_w;
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
    import tmc_pkg::*;
#(
    parameter int PER_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              carry,
    input logic              load,
    input logic [CNT_W-1:0]  load_val,
    input logic [PER_W-1:0]  period,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick,
    input logic [CNT_W-1:0]  offset,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr
);
    localparam int PAD = CNT_W - PER_W;

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (en && carry && !load) |=> (tick && cnt == $past(cnt) + {{PAD{1'b0}}, $past(period)})) // R2
        else $error("step did not advance count");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(en && carry) && !load) |=> (!tick && $stable(cnt))) // R4
        else $error("count moved without a step");

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(en)) // R3
        else $error("tick while disabled");

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))) // R7
        else $error("count load lost");

    AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 3'd5) |=> $stable(offset)) // R8
        else $error("offset changed without commit");
endmodule

bind tmc_top tmc_checker #(.PER_W(PER_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en_w),
    .carry   (carry_w),
    .load    (load_en_w),
    .load_val(load_val_w),
    .period  (period_w),
    .cnt     (raw_cnt_o),
    .tick    (tick_o),
    .offset  (offset_w),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr)
);

// File: tb/tmc_top_test.sv
module tmc_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] raw_cnt;
    logic [63:0] time_val;
    logic        tick;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    bit done   = 0;

    tmc_top uut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .raw_cnt_o(raw_cnt),
        .time_o   (time_val),
        .tick_o   (tick)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (tick) ticks++;

    function automatic longint unsigned carries(input longint unsigned n,
                                                input longint unsigned a);
        return (n * a) >> 32;
    endfunction

    function automatic logic [63:0] exp_cnt(input logic [63:0] start, input longint unsigned n,
                                            input longint unsigned a, input longint unsigned p);
        return start + carries(n, a) * p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #2; d = bus_rdata;
        @(posedge clk); #1; bus_rd = 1'b0;
    endtask

    task automatic write64(input logic [2:0] lo_addr, input logic [63:0] v);
        bus_write(lo_addr, v[31:0]);
        bus_write(lo_addr + 3'd1, v[63:32]);
    endtask

    // enable for exactly n (>=1) accumulation edges, then disable
    task automatic run(input logic [7:0] per, input int n);
        bus_write(3'd0, {16'd0, per, 8'h01});
        repeat (n - 1) @(negedge clk);
        bus_write(3'd0, {16'd0, per, 8'h00});
        @(negedge clk); #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, lo, hi;
        logic [63:0] hold;
        void'($urandom(32'd4242));
        do_reset();

        // R1 reset state
        @(negedge clk); #1;
        check("R1 raw", raw_cnt, 64'd0);
        check("R1 time", time_val, 64'd0);
        check("R1 tick", {63'd0, tick}, 64'd0);
        bus_read(3'd0, d); check("R1 ctrl", {32'd0, d}, 64'h0A00);
        bus_read(3'd1, d); check("R1 addend", {32'd0, d}, 64'hCCCC_CCCD);

        // R9 control and addend fields
        bus_write(3'd0, 32'h0000_2500);
        bus_read(3'd0, d); check("R9 ctrl rb", {32'd0, d}, 64'h2500);
        bus_write(3'd0, 32'hFFFF_FFFE);
        bus_read(3'd0, d); check("R9 ctrl mask", {32'd0, d}, 64'hFF00);
        bus_write(3'd1, 32'h1357_9BDF);
        bus_read(3'd1, d); check("R9 addend rb", {32'd0, d}, 64'h1357_9BDF);

        // R2 half addend: a step every second cycle
        do_reset();
        bus_write(3'd1, 32'h8000_0000);
        ticks = 0;
        run(8'd10, 20);
        check("R2 half count", raw_cnt, 64'd100);
        check("R3 half ticks", ticks, 64'd10);

        // R2 zero addend: no motion
        do_reset();
        bus_write(3'd1, 32'h0);
        ticks = 0;
        run(8'd10, 30);
        check("R2 zero count", raw_cnt, 64'd0);
        check("R3 zero ticks", ticks, 64'd0);

        // R2/R3/R4/R6 random runs with a pause in the middle
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a;
            logic [7:0]  p;
            logic [63:0] s;
            int n1, n2;
            a  = $urandom() | 32'd1;
            p  = 8'($urandom_range(255, 1));
            s  = {$urandom(), $urandom()};
            n1 = $urandom_range(300, 20);
            n2 = $urandom_range(300, 20);
            do_reset();
            bus_write(3'd1, a);
            write64(3'd2, s);
            ticks = 0;
            run(p, n1);
            check("R2 rand count", raw_cnt, exp_cnt(s, n1, a, p));
            check("R3 rand ticks", ticks, carries(n1, a));
            hold = raw_cnt;
            repeat (40) @(negedge clk);
            #1;
            check("R4 hold count", raw_cnt, hold);
            check("R4 hold ticks", ticks, carries(n1, a));
            run(p, n2);
            check("R4 resume count", raw_cnt, exp_cnt(s, n1 + n2, a, p));
            bus_read(3'd2, lo);
            bus_read(3'd3, hi);
            check("R6 rand readback", {hi, lo}, exp_cnt(s, n1 + n2, a, p));
        end

        // R6 coherent high word across a carry into the high half
        do_reset();
        bus_write(3'd1, 32'hFFFF_FFFF);
        write64(3'd2, 64'h0000_0001_FFFF_FFF0);
        bus_write(3'd0, 32'h0000_0401);
        bus_read(3'd2, lo);
        check("R6 live low", {32'd0, lo}, 64'hFFFF_FFF0);
        repeat (12) @(negedge clk);
        #1;
        check("R6 count moved on", {32'd0, raw_cnt[63:32]}, 64'd2);
        bus_read(3'd3, hi);
        check("R6 shadow high", {32'd0, hi}, 64'd1);

        // R7 load wins over an active step (still enabled, carrying each cycle)
        bus_write(3'd2, 32'h0000_0100);
        bus_write(3'd3, 32'h0);
        check("R7 load priority", raw_cnt, 64'h100);

        // R7 staged low word
        do_reset();
        bus_write(3'd2, 32'h0000_1234);
        @(negedge clk); #1;
        check("R7 staged no change", raw_cnt, 64'd0);
        bus_write(3'd3, 32'h0000_00AB);
        check("R7 commit", raw_cnt, 64'h0000_00AB_0000_1234);

        // R5/R8 offset
        do_reset();
        write64(3'd2, 64'h0000_0005_0000_0010);
        bus_write(3'd4, 32'hFFFF_FFF0);
        @(negedge clk); #1;
        check("R8 offset staged", time_val, 64'h0000_0005_0000_0010);
        bus_write(3'd5, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        check("R5 raw untouched", raw_cnt, 64'h0000_0005_0000_0010);
        check("R5 time wraps", time_val, 64'h0000_0005_0000_0000);
        bus_read(3'd4, lo);
        bus_read(3'd5, hi);
        check("R8 offset rb", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFF0);
        bus_write(3'd1, 32'h9000_0000);
        bus_write(3'd0, 32'h0000_0701);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            check("R5 running sum", time_val, raw_cnt + 64'hFFFF_FFFF_FFFF_FFF0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule